// File: doc/BRIEF.md
# Decimal successive-subtraction divider

This block divides one packed-BCD operand by another and returns a short run of significant quotient digits together with a decimal-point position. It is intended for a measurement counter. Depending on the measurement mode, the counter needs either numerator/denominator or the inverse. When the mode asks for the inverse, the block first exchanges its two operand registers through a holding latch.

Division is a decimal long division. The block brings down one dividend digit at a time into a remainder register, moving the remainder up one decimal place on each bring-down. It then subtracts the divisor repeatedly until a borrow would occur. The number of successful subtractions is the quotient digit.

Leading zero digits are not stored; each one that is skipped advances a decimal-point counter. The run ends once the requested number of significant digits has been collected, or after twice the operand width in digit steps. The collected quotient is then written into the denominator register, which drives the result output until the next start.

Top module: `dec_div`

## Requirements
- R1: With swap_i = 0 the dividend A is num_i and the divisor B is den_i. Both are packed BCD, and digit k occupies bits [4k+3:4k], with digit NDIG-1 the most significant.
- R2: With swap_i = 1 the operand registers are exchanged before dividing, so A is den_i and B is num_i.
- R3: Digit step j (j = 1, 2, ...) produces the digit floor(A*10^j / (B*10^NDIG)) mod 10. This digit equals the count of borrow-free subtractions in that step and never exceeds 9.
- R4: The significant-digit limit D is digits_i, with 0 read as 1 and values above NDIG read as NDIG. Digits are collected from the first nonzero digit onward until D have been collected. quot_o holds them right-aligned: the last digit is in bits [3:0] and unused upper digits are 0.
- R5: dp_o equals the number of leading zero digit steps skipped before the first nonzero digit.
- R6: A run stops after 2*NDIG digit steps even if fewer than D digits were collected. A zero dividend therefore ends with quot_o = 0 and dp_o = 2*NDIG.
- R7: A zero divisor ends the run without dividing: done_o pulses with err_o = 1, quot_o = 0 and dp_o = 0. err_o is 0 after any run with a nonzero divisor.
- R8: busy_o is high from the cycle after an accepted start up to and including the cycle in which done_o is high. done_o is high for exactly one cycle.
- R9: start_i is ignored while busy_o is high: neither the operands, the mode nor the digit limit of the run in progress change.
- R10: While idle and without a new start, quot_o, dp_o and err_o hold the last run's result whatever the other inputs do.
- R11: After reset busy_o, done_o and err_o are 0, and quot_o and dp_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division when idle |
| swap_i | input | 1 | 1 = exchange operands before dividing |
| num_i | input | 4*NDIG | Numerator operand, packed BCD |
| den_i | input | 4*NDIG | Denominator operand, packed BCD |
| digits_i | input | $clog2(NDIG+1) | Requested significant digit count |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run had a zero divisor |
| quot_o | output | 4*NDIG | Quotient digits, packed BCD, right-aligned |
| dp_o | output | $clog2(2*NDIG+1) | Skipped leading-zero steps |

## Verification
The bench runs a 4-digit configuration. It sweeps every pairing of twelve operand values, including 0, 1, single digits, repeating fractions and all-nines, in both modes. The pairings separate exact quotients from non-terminating ones, small-over-large cases with many skipped zeros from large-over-small cases whose first step already yields a digit, and zero dividends that reach the step limit from zero divisors that abort. The requested digit count cycles through 0 to 5, so the clamping at both ends is tried against the same operand pairs. A start issued mid-run and input changes while idle show whether the held result can be disturbed.

// File: rtl/dec_div_pkg.sv
package dec_div_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_XRD, S_XWN, S_XWD, S_CHK, S_BRING, S_SUB, S_MOVE, S_DONE
  } st_e;
endpackage

// File: rtl/dec_div_sub.sv
module dec_div_sub #(
  parameter int unsigned ND = 9
) (
  input  logic [4*ND-1:0] a_i,
  input  logic [4*ND-1:0] b_i,
  output logic [4*ND-1:0] d_o,
  output logic            borrow_o
);
  always_comb begin
    logic       bw;
    logic [4:0] t;
    bw = 1'b0;
    d_o = '0;
    for (int k = 0; k < int'(ND); k++) begin
      t = {1'b0, a_i[4*k +: 4]} - {1'b0, b_i[4*k +: 4]} - {4'd0, bw};
      d_o[4*k +: 4] = t[4] ? (t[3:0] + 4'd10) : t[3:0];
      bw = t[4];
    end
    borrow_o = bw;
  end
endmodule

// File: rtl/dec_div_opregs.sv
module dec_div_opregs #(
  parameter int unsigned ND = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [4*ND-1:0] num_ld_i,
  input  logic [4*ND-1:0] den_ld_i,
  input  logic            lat_i,
  input  logic            wnum_i,
  input  logic            wden_i,
  input  logic            shl_i,
  input  logic            res_we_i,
  input  logic [4*ND-1:0] res_i,
  output logic [4*ND-1:0] num_o,
  output logic [4*ND-1:0] den_o
);
  logic [4*ND-1:0] num_q, den_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_q <= '0;
      den_q <= '0;
      lat_q <= '0;
    end else if (load_i) begin
      num_q <= num_ld_i;
      den_q <= den_ld_i;
    end else begin
      // exchange runs as three strobes: latch <- num, num <- den, den <- latch
      if (lat_i)    lat_q <= num_q;
      if (wnum_i)   num_q <= den_q;
      if (wden_i)   den_q <= lat_q;
      if (shl_i)    num_q <= {num_q[4*ND-5:0], 4'h0};
      if (res_we_i) den_q <= res_i;
    end
  end

  assign num_o = num_q;
  assign den_o = den_q;

  a_r2_shift_fills_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shl_i && !load_i) |=> (num_o[3:0] == 4'h0));
endmodule

// File: rtl/dec_div.sv
module dec_div
  import dec_div_pkg::*;
#(
  parameter int unsigned NDIG = 8,
  localparam int unsigned DCW = $clog2(NDIG + 1),
  localparam int unsigned PW  = $clog2(2 * NDIG + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              swap_i,
  input  logic [4*NDIG-1:0] num_i,
  input  logic [4*NDIG-1:0] den_i,
  input  logic [DCW-1:0]    digits_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [4*NDIG-1:0] quot_o,
  output logic [PW-1:0]     dp_o
);
  localparam int unsigned RW    = 4 * (NDIG + 1);
  localparam int unsigned NSTEP = 2 * NDIG;

  st_e              st_q;
  logic [RW-1:0]    rem_q, diff;
  logic             borrow;
  logic [3:0]       cnt_q;
  logic [4*NDIG-1:0] quot_q;
  logic [DCW-1:0]   dc_q, dlim_q, dlim_in, dc_nx;
  logic [PW-1:0]    step_q, dp_q;
  logic             sig_q, err_q, mode_q;
  logic             digit_sig, last;
  logic [4*NDIG-1:0] num_w, den_w;
  logic             load, lat, wnum, wden, shl, res_we;

  always_comb begin
    if (digits_i == '0)                 dlim_in = DCW'(1);
    else if (digits_i > DCW'(NDIG))     dlim_in = DCW'(NDIG);
    else                                dlim_in = digits_i;
  end

  assign load   = (st_q == S_IDLE) && start_i;
  assign lat    = (st_q == S_XRD);
  assign wnum   = (st_q == S_XWN);
  assign wden   = (st_q == S_XWD);
  assign shl    = (st_q == S_BRING);
  assign res_we = (st_q == S_MOVE);

  dec_div_opregs #(.ND(NDIG)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .num_ld_i(num_i),
    .den_ld_i(den_i),
    .lat_i   (lat),
    .wnum_i  (wnum),
    .wden_i  (wden),
    .shl_i   (shl),
    .res_we_i(res_we),
    .res_i   (quot_q),
    .num_o   (num_w),
    .den_o   (den_w)
  );

  dec_div_sub #(.ND(NDIG + 1)) u_sub (
    .a_i     (rem_q),
    .b_i     ({4'h0, den_w}),
    .d_o     (diff),
    .borrow_o(borrow)
  );

  // a zero digit before the first nonzero one is skipped, not stored
  assign digit_sig = sig_q || (cnt_q != 4'd0);
  assign dc_nx     = digit_sig ? dc_q + DCW'(1) : dc_q;
  assign last      = (dc_nx == dlim_q) || (step_q == PW'(NSTEP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      rem_q  <= '0;
      cnt_q  <= '0;
      quot_q <= '0;
      dc_q   <= '0;
      dlim_q <= DCW'(1);
      step_q <= '0;
      dp_q   <= '0;
      sig_q  <= 1'b0;
      err_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          rem_q  <= '0;
          cnt_q  <= '0;
          quot_q <= '0;
          dc_q   <= '0;
          dlim_q <= dlim_in;
          step_q <= '0;
          dp_q   <= '0;
          sig_q  <= 1'b0;
          err_q  <= 1'b0;
          mode_q <= swap_i;
          st_q   <= swap_i ? S_XRD : S_CHK;
        end
        S_XRD: st_q <= S_XWN;
        S_XWN: st_q <= S_XWD;
        S_XWD: st_q <= S_CHK;
        S_CHK: begin
          if (den_w == '0) begin
            err_q <= 1'b1;
            st_q  <= S_DONE;
          end else begin
            st_q  <= S_BRING;
          end
        end
        S_BRING: begin
          rem_q <= {rem_q[4*NDIG-1:0], num_w[4*NDIG-1 -: 4]};
          cnt_q <= '0;
          st_q  <= S_SUB;
        end
        S_SUB: begin
          if (!borrow) begin
            rem_q <= diff;
            cnt_q <= cnt_q + 4'd1;
          end else begin
            step_q <= step_q + PW'(1);
            if (digit_sig) begin
              sig_q  <= 1'b1;
              quot_q <= {quot_q[4*NDIG-5:0], cnt_q};
              dc_q   <= dc_nx;
            end else begin
              dp_q <= dp_q + PW'(1);
            end
            st_q <= last ? S_MOVE : S_BRING;
          end
        end
        S_MOVE: st_q <= S_DONE;
        S_DONE: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign done_o = (st_q == S_DONE);
  assign err_o  = err_q;
  assign quot_o = den_w;
  assign dp_o   = dp_q;

  a_r3_digit_le9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_SUB) |-> (cnt_q <= 4'd9));
  a_r4_dc_in_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (dc_q <= dlim_q));
  a_r6_step_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (step_q <= PW'(NSTEP)));
  a_r7_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (quot_o == '0 && dp_o == '0));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(dlim_q) && $stable(mode_q)));
  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quot_o) && $stable(dp_o) && $stable(err_o)));
endmodule

// File: tb/dec_div_bench.sv
module dec_div_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         start_i, swap_i;
  logic [4*N-1:0] num_i, den_i;
  logic [2:0]   digits_i;
  logic         busy_o, done_o, err_o;
  logic [4*N-1:0] quot_o;
  logic [3:0]   dp_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dec_div #(.NDIG(N)) u_dec_div (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .swap_i(swap_i),
    .num_i(num_i), .den_i(den_i), .digits_i(digits_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o),
    .quot_o(quot_o), .dp_o(dp_o)
  );

  function automatic logic [4*N-1:0] to_bcd(longint v);
    logic [4*N-1:0] r;
    r = '0;
    for (int k = 0; k < N; k++) begin
      r[4*k +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  // expected result straight from the requirement arithmetic
  task automatic model(input longint a, input longint b, input int d,
                       output logic [4*N-1:0] q, output int dp, output bit e);
    longint qv, pw, p;
    int lim, dc;
    bit sig;
    lim = (d == 0) ? 1 : ((d > N) ? N : d);
    qv = 0; dp = 0; dc = 0; sig = 0; e = 0;
    if (b == 0) begin
      e = 1;
    end else begin
      pw = 1;
      for (int j = 1; j <= 2 * N; j++) begin
        pw = pw * 10;
        p = ((a * pw) / (b * 10000)) % 10;
        if (!sig && p == 0) dp++;
        else begin
          sig = 1; qv = qv * 10 + p; dc++;
        end
        if (dc == lim) break;
      end
    end
    q = to_bcd(qv);
  endtask

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 400) begin
      @(negedge clk);
      n++;
    end
    chk(done_o, "R8 done reached", longint'(done_o), 1);
  endtask

  task automatic do_op(int a, int b, bit md, int d);
    logic [4*N-1:0] eq;
    int edp;
    bit ee;
    string tq;
    if (md) model(b, a, d, eq, edp, ee);
    else    model(a, b, d, eq, edp, ee);
    tq = md ? "R2 quotient" : "R1 quotient";
    if (d == 0 || d > N) tq = {tq, " R4 clamp"};
    if ((md ? b : a) == 0) tq = {tq, " R6 cap"};
    @(negedge clk);
    num_i = to_bcd(a); den_i = to_bcd(b); swap_i = md; digits_i = 3'(d); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R8 busy", longint'(busy_o), 1);
    wait_done();
    chk(quot_o == eq, tq, longint'(quot_o), longint'(eq));       // R3 R4
    chk(int'(dp_o) == edp, "R5 dp", longint'(dp_o), edp);
    chk(err_o == ee, "R7 err", longint'(err_o), longint'(ee));
    @(negedge clk);
    chk(!done_o && !busy_o, "R8 pulse", longint'({busy_o, done_o}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int vals[12] = '{0, 1, 2, 7, 10, 33, 99, 123, 500, 999, 4321, 9999};
    logic [4*N-1:0] sq, eq;
    logic [3:0] sdp;
    bit se, ee;
    int edp;

    rst_ni = 1'b0; start_i = 1'b0; swap_i = 1'b0;
    num_i = '0; den_i = '0; digits_i = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R11
    chk(!busy_o && !done_o && !err_o, "R11 flags", longint'({busy_o, done_o, err_o}), 0);
    chk(quot_o == '0 && dp_o == '0, "R11 result", longint'(quot_o), 0);

    for (int md = 0; md < 2; md++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          do_op(vals[i], vals[j], md[0], (i + j + md) % 6);

    // R9: second start mid-run must not disturb the run
    model(1234, 7, 4, eq, edp, ee);
    @(negedge clk);
    num_i = to_bcd(1234); den_i = to_bcd(7); swap_i = 1'b0; digits_i = 3'd4; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    num_i = to_bcd(9999); den_i = to_bcd(1); swap_i = 1'b1; digits_i = 3'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait_done();
    chk(quot_o == eq, "R9 quotient", longint'(quot_o), longint'(eq));
    chk(int'(dp_o) == edp, "R9 dp", longint'(dp_o), edp);

    // R10: idle hold with changing inputs
    sq = quot_o; sdp = dp_o; se = err_o;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      num_i = to_bcd(k * 111); den_i = '0; swap_i = k[0]; digits_i = 3'(k);
    end
    @(negedge clk);
    chk(quot_o == sq, "R10 quotient hold", longint'(quot_o), longint'(sq));
    chk(dp_o == sdp && err_o == se, "R10 dp/err hold", longint'({err_o, dp_o}), longint'({se, sdp}));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule